// File: doc/BRIEF.md
# Data-Stationary Pipeline Control Sequencer

This block is the control section of a six-stage in-order instruction pipeline. An instruction enters stage 1 with its opcode, its destination register and its address-source register. In stage 2 the block reads exactly one wide control word for it. The word holds one 8-bit group for each of stages 2 to 6 and a multi-cycle count. The groups for the later stages then travel with the instruction through a chain of stage registers. Each group is dropped once its stage has used it. A stage's control bus therefore shows the group of whichever instruction currently sits in that stage, and all zeros when the stage is empty.

With no hazards the pipeline accepts one instruction per clock, and each instruction takes six clocks from entry to result. There is one hazard that costs a cycle: an integer result that the next instruction uses as an address. In that case a single all-zero bubble goes into stage 3 while stages 1 and 2 wait. Other data dependencies are taken as forwarded in time. A branch that follows a compare is not held back. A multi-cycle operation stays in the final execute stage for extra clocks, and every stage behind it freezes during that time.

Top module: `dsc_pipe_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every control bus is zero, stall_o, hold_o and retire_o are low, and in_ready_o is high.
- R2: The control group for stage s (s = 2..6) of an instruction with opcode o is {o[4:0], s[2:0]}. The multi-cycle count is o[1:0] when o[3] is 1, and 0 otherwise.
- R3: With no stall and no hold, an instruction accepted at clock edge k shows its stage-s group after edge k+s-1, and retire_o is high in the cycle after edge k+5. One instruction can be accepted on every clock.
- R4: A stage's control bus carries an instruction's group only while that instruction occupies the stage. An empty stage drives zero.
- R5: The block stalls when three things hold: the stage-2 instruction has o[5]=1 (it uses a register as an address), the stage-3 instruction has o[4]=1 (it writes an integer result), and the address register of the first equals the destination of the second. During that cycle stall_o is high and in_ready_o is low. Stages 1 and 2 keep their contents, and stage 3 receives a zero bubble on the next edge.
- R6: No stall occurs when the registers differ, when the producer has o[4]=0, when the consumer has o[5]=0, or when another instruction or a bubble separates the two.
- R7: An instruction with o[3]=1 stays in stage 6 for 1+o[1:0] cycles. hold_o is high in every one of those cycles except the last.
- R8: While hold_o is high, every stage keeps its contents, in_ready_o is low, no bubble is inserted and stall_o stays low.
- R9: retire_o is high for exactly one cycle per valid instruction, in its last cycle in stage 6.
- R10: Asserting rst_n low during operation empties every stage at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid_i | input | 1 | An instruction is offered |
| in_ready_o | output | 1 | The instruction offered is taken on this edge |
| in_opc_i | input | OPC_W | Decoded opcode |
| in_dst_i | input | REG_W | Destination register index |
| in_asrc_i | input | REG_W | Register used as the address source |
| ctl2_o | output | GRP_W | Stage-2 control group |
| ctl3_o | output | GRP_W | Stage-3 control group |
| ctl4_o | output | GRP_W | Stage-4 control group |
| ctl5_o | output | GRP_W | Stage-5 control group |
| ctl6_o | output | GRP_W | Stage-6 control group |
| stall_o | output | 1 | A bubble is inserted into stage 3 this cycle |
| hold_o | output | 1 | A multi-cycle operation holds the pipe this cycle |
| retire_o | output | 1 | A valid instruction leaves stage 6 on this edge |

## Verification
The bench builds the block with the default 8-bit groups and 6-bit opcode, but narrows the register index to 3 bits. With only eight registers, random address and destination fields collide often. This brings back-to-back address hazards, hazards that arrive behind a multi-cycle hold, and hold lengths of one to four cycles into a short random run. Directed sequences cover each no-stall case and a reset in the middle of a run.

// File: rtl/dsc_pkg.sv
`timescale 1ns/1ps
package dsc_pkg;
  localparam int unsigned N_STAGE   = 6;
  localparam int unsigned FIRST_CTL = 2;
  localparam int unsigned N_GROUP   = N_STAGE - FIRST_CTL + 1;
  localparam int unsigned TAG_W     = 3;
  // opcode flag positions
  localparam int unsigned OPB_ADDR  = 5;
  localparam int unsigned OPB_IWR   = 4;
  localparam int unsigned OPB_MC    = 3;
  localparam int unsigned MC_W      = 2;
endpackage

// File: rtl/dsc_ustore.sv
`timescale 1ns/1ps
module dsc_ustore
  import dsc_pkg::*;
#(
  parameter int unsigned GRP_W = 8
) (
  input  logic [GRP_W-TAG_W-1:0]         opf_i,
  output logic [(N_GROUP+1)*GRP_W-1:0]   uword_o
);
  // one group per controlled stage, then the multi-cycle count on top
  for (genvar s = FIRST_CTL; s <= N_STAGE; s++) begin : g_grp
    assign uword_o[(s-FIRST_CTL)*GRP_W +: GRP_W] = {opf_i, TAG_W'(s)};
  end

  assign uword_o[N_GROUP*GRP_W +: GRP_W] =
    opf_i[OPB_MC] ? GRP_W'(opf_i[MC_W-1:0]) : '0;
endmodule

// File: rtl/dsc_hazard.sv
`timescale 1ns/1ps
module dsc_hazard #(
  parameter int unsigned REG_W = 4
) (
  input  logic             v2_i,
  input  logic             use_addr2_i,
  input  logic [REG_W-1:0] asrc2_i,
  input  logic             v3_i,
  input  logic             iwr3_i,
  input  logic [REG_W-1:0] dst3_i,
  output logic             haz_o
);
  assign haz_o = v2_i && use_addr2_i && v3_i && iwr3_i && (asrc2_i == dst3_i);
endmodule

// File: rtl/dsc_mc_hold.sv
`timescale 1ns/1ps
module dsc_mc_hold #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v6_i,
  input  logic [CW-1:0] cnt_i,
  output logic          hold_o
);
  logic [CW-1:0] spent_q, spent_d;

  assign hold_o = v6_i && (spent_q != cnt_i);

  always_comb begin
    spent_d = hold_o ? spent_q + CW'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spent_q <= '0;
    else        spent_q <= spent_d;
  end
endmodule

// File: rtl/dsc_pipe_ctrl.sv
`timescale 1ns/1ps
module dsc_pipe_ctrl
  import dsc_pkg::*;
#(
  parameter int unsigned OPC_W = 6,
  parameter int unsigned GRP_W = 8,
  parameter int unsigned REG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [OPC_W-1:0] in_opc_i,
  input  logic [REG_W-1:0] in_dst_i,
  input  logic [REG_W-1:0] in_asrc_i,
  output logic [GRP_W-1:0] ctl2_o,
  output logic [GRP_W-1:0] ctl3_o,
  output logic [GRP_W-1:0] ctl4_o,
  output logic [GRP_W-1:0] ctl5_o,
  output logic [GRP_W-1:0] ctl6_o,
  output logic             stall_o,
  output logic             hold_o,
  output logic             retire_o
);
  localparam int unsigned UW_W  = (N_GROUP + 1) * GRP_W;
  localparam int unsigned OPF_W = GRP_W - TAG_W;

  // stages 1 and 2: instruction identity before and at lookup
  logic             v1_q, v1_d, v2_q, v2_d;
  logic [OPC_W-1:0] opc1_q, opc1_d, opc2_q, opc2_d;
  logic [REG_W-1:0] dst1_q, dst1_d, dst2_q, dst2_d;
  logic [REG_W-1:0] asrc1_q, asrc1_d, asrc2_q, asrc2_d;
  // stage 3 side information for the hazard check
  logic             iwr3_q, iwr3_d;
  logic [REG_W-1:0] dst3_q, dst3_d;

  logic [UW_W-1:0]  uword;
  logic             haz, hold, adv_lo, adv_hi;

  dsc_ustore #(.GRP_W(GRP_W)) u_store (
    .opf_i  (opc2_q[OPF_W-1:0]),
    .uword_o(uword)
  );

  assign adv_hi = !hold;
  assign adv_lo = !hold && !haz;

  // ---------------- stages 1..2 ----------------
  always_comb begin
    v1_d    = in_valid_i;
    opc1_d  = in_opc_i;
    dst1_d  = in_dst_i;
    asrc1_d = in_asrc_i;
    v2_d    = v1_q;
    opc2_d  = opc1_q;
    dst2_d  = dst1_q;
    asrc2_d = asrc1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0; opc1_q <= '0; dst1_q <= '0; asrc1_q <= '0;
      v2_q <= 1'b0; opc2_q <= '0; dst2_q <= '0; asrc2_q <= '0;
    end else if (adv_lo) begin
      v1_q <= v1_d; opc1_q <= opc1_d; dst1_q <= dst1_d; asrc1_q <= asrc1_d;
      v2_q <= v2_d; opc2_q <= opc2_d; dst2_q <= dst2_d; asrc2_q <= asrc2_d;
    end
  end

  // ---------------- stages 3..6: delayed control groups ----------------
  for (genvar k = FIRST_CTL + 1; k <= N_STAGE; k++) begin : g_st
    localparam int unsigned W = (N_STAGE - k + 2) * GRP_W;
    logic         v_q, v_d, v_src;
    logic [W-1:0] pay_q, pay_d, src;

    if (k == FIRST_CTL + 1) begin : g_in
      assign v_src = v2_q && !haz;
      assign src   = uword[UW_W-1:GRP_W];
    end else begin : g_in
      assign v_src = g_st[k-1].v_q;
      assign src   = g_st[k-1].pay_q[(N_STAGE-k+3)*GRP_W-1:GRP_W];
    end

    always_comb begin
      v_d   = v_src;
      pay_d = v_src ? src : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q   <= 1'b0;
        pay_q <= '0;
      end else if (adv_hi) begin
        v_q   <= v_d;
        pay_q <= pay_d;
      end
    end
  end

  always_comb begin
    iwr3_d = v2_q && !haz && opc2_q[OPB_IWR];
    dst3_d = dst2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iwr3_q <= 1'b0;
      dst3_q <= '0;
    end else if (adv_hi) begin
      iwr3_q <= iwr3_d;
      dst3_q <= dst3_d;
    end
  end

  dsc_hazard #(.REG_W(REG_W)) u_haz (
    .v2_i       (v2_q),
    .use_addr2_i(opc2_q[OPB_ADDR]),
    .asrc2_i    (asrc2_q),
    .v3_i       (g_st[3].v_q),
    .iwr3_i     (iwr3_q),
    .dst3_i     (dst3_q),
    .haz_o      (haz)
  );

  dsc_mc_hold #(.CW(GRP_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .v6_i  (g_st[6].v_q),
    .cnt_i (g_st[6].pay_q[GRP_W +: GRP_W]),
    .hold_o(hold)
  );

  assign ctl2_o     = v2_q ? uword[GRP_W-1:0] : '0;
  assign ctl3_o     = g_st[3].pay_q[GRP_W-1:0];
  assign ctl4_o     = g_st[4].pay_q[GRP_W-1:0];
  assign ctl5_o     = g_st[5].pay_q[GRP_W-1:0];
  assign ctl6_o     = g_st[6].pay_q[GRP_W-1:0];
  assign hold_o     = hold;
  assign stall_o    = haz && !hold;
  assign in_ready_o = adv_lo;
  assign retire_o   = g_st[6].v_q && !hold;
endmodule

// File: rtl/dsc_pipe_chk.sv
`timescale 1ns/1ps
module dsc_pipe_chk
  import dsc_pkg::*;
#(
  parameter int unsigned GRP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [GRP_W-1:0] ctl2_i,
  input logic [GRP_W-1:0] ctl3_i,
  input logic [GRP_W-1:0] ctl4_i,
  input logic [GRP_W-1:0] ctl5_i,
  input logic [GRP_W-1:0] ctl6_i,
  input logic             stall_i,
  input logic             hold_i,
  input logic             retire_i
);
  // R5
  bubble_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ctl3_i == '0);

  // R5
  stall_keeps_s2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(ctl2_i));

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> ($stable(ctl2_i) && $stable(ctl3_i) && $stable(ctl4_i) && $stable(ctl5_i)));

  // R4
  travel_34_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_i |=> ctl4_i[GRP_W-1:TAG_W] == $past(ctl3_i[GRP_W-1:TAG_W]));

  // R4
  travel_56_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_i |=> ctl6_i[GRP_W-1:TAG_W] == $past(ctl5_i[GRP_W-1:TAG_W]));

  // R2
  stage6_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl6_i != '0) |-> ctl6_i[TAG_W-1:0] == TAG_W'(N_STAGE));

  // R6
  no_stall_empty3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl3_i == '0) |-> !stall_i);

  // R9
  retire_occupied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_i |-> ctl6_i[TAG_W-1:0] == TAG_W'(N_STAGE));
endmodule

bind dsc_pipe_ctrl dsc_pipe_chk #(.GRP_W(GRP_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ctl2_i  (ctl2_o),
  .ctl3_i  (ctl3_o),
  .ctl4_i  (ctl4_o),
  .ctl5_i  (ctl5_o),
  .ctl6_i  (ctl6_o),
  .stall_i (stall_o),
  .hold_i  (hold_o),
  .retire_i(retire_o)
);

// File: tb/sim_dsc_pipe_ctrl.sv
`timescale 1ns/1ps
module sim_dsc_pipe_ctrl;
  localparam int unsigned OPC_W = 6;
  localparam int unsigned GRP_W = 8;
  localparam int unsigned REG_W = 3;
  localparam int MQ = 1024;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid_i;
  logic             in_ready_o;
  logic [OPC_W-1:0] in_opc_i;
  logic [REG_W-1:0] in_dst_i, in_asrc_i;
  logic [GRP_W-1:0] ctl2_o, ctl3_o, ctl4_o, ctl5_o, ctl6_o;
  logic             stall_o, hold_o, retire_o;

  always #5 clk = ~clk;

  dsc_pipe_ctrl #(.OPC_W(OPC_W), .GRP_W(GRP_W), .REG_W(REG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_opc_i(in_opc_i), .in_dst_i(in_dst_i), .in_asrc_i(in_asrc_i),
    .ctl2_o(ctl2_o), .ctl3_o(ctl3_o), .ctl4_o(ctl4_o), .ctl5_o(ctl5_o), .ctl6_o(ctl6_o),
    .stall_o(stall_o), .hold_o(hold_o), .retire_o(retire_o)
  );

  int checks = 0;
  int errors = 0;

  // behavioural model: which instruction id sits in each stage (-1 empty)
  int               occ [1:6];
  logic [OPC_W-1:0] mopc [MQ];
  logic [REG_W-1:0] mdst [MQ];
  logic [REG_W-1:0] masrc [MQ];
  int               mrem;
  int               nid;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_grp(input int k);
    if (occ[k] < 0) return 0;
    return int'({mopc[occ[k]][4:0], 3'(k)});
  endfunction

  function automatic bit m_haz();
    if (occ[2] < 0 || occ[3] < 0) return 1'b0;
    return mopc[occ[2]][5] && mopc[occ[3]][4] && (masrc[occ[2]] == mdst[occ[3]]);
  endfunction

  function automatic bit m_hold();
    return (occ[6] >= 0) && (mrem > 0);
  endfunction

  task automatic compare_all();
    bit hz, hd;
    hz = m_haz();
    hd = m_hold();
    chk("R2 R4", "ctl2", int'(ctl2_o), exp_grp(2));
    chk("R2 R4", "ctl3", int'(ctl3_o), exp_grp(3));
    chk("R2 R4", "ctl4", int'(ctl4_o), exp_grp(4));
    chk("R2 R4", "ctl5", int'(ctl5_o), exp_grp(5));
    chk("R2 R4", "ctl6", int'(ctl6_o), exp_grp(6));
    chk("R5 R6", "stall", int'(stall_o), int'(hz && !hd));
    chk("R7 R8", "hold", int'(hold_o), int'(hd));
    chk("R3 R9", "retire", int'(retire_o), int'(occ[6] >= 0 && !hd));
    chk("R5 R8", "ready", int'(in_ready_o), int'(!hd && !hz));
  endtask

  task automatic model_clear();
    for (int k = 1; k <= 6; k++) occ[k] = -1;
    mrem = 0;
  endtask

  task automatic step(input bit v, input logic [OPC_W-1:0] o,
                      input logic [REG_W-1:0] d, input logic [REG_W-1:0] a,
                      output bit acc);
    bit hz, hd;
    @(negedge clk);
    compare_all();
    in_valid_i = v; in_opc_i = o; in_dst_i = d; in_asrc_i = a;
    hz  = m_haz();
    hd  = m_hold();
    acc = v && !hz && !hd;
    if (hd) begin
      mrem--;
    end else begin
      occ[6] = occ[5];
      mrem   = (occ[6] >= 0 && mopc[occ[6]][3]) ? int'(mopc[occ[6]][1:0]) : 0;
      occ[5] = occ[4];
      occ[4] = occ[3];
      if (hz) begin
        occ[3] = -1;
      end else begin
        occ[3] = occ[2];
        occ[2] = occ[1];
        if (v) begin
          mopc[nid] = o; mdst[nid] = d; masrc[nid] = a;
          occ[1] = nid;
          nid = (nid + 1) % MQ;
        end else begin
          occ[1] = -1;
        end
      end
    end
  endtask

  task automatic send(input logic [OPC_W-1:0] o, input logic [REG_W-1:0] d,
                      input logic [REG_W-1:0] a);
    bit acc;
    do step(1'b1, o, d, a, acc); while (!acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, acc);
  endtask

  task automatic reset_checks(input string tag);
    chk(tag, "rst ctl", int'(ctl2_o | ctl3_o | ctl4_o | ctl5_o | ctl6_o), 0);
    chk(tag, "rst stall/hold/retire", int'({stall_o, hold_o, retire_o}), 0);
    chk(tag, "rst ready", int'(in_ready_o), 1);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    nid = 0;
    model_clear();
    rst_n = 1'b0; in_valid_i = 1'b0; in_opc_i = '0; in_dst_i = '0; in_asrc_i = '0;
    repeat (2) @(negedge clk);
    reset_checks("R1");
    rst_n = 1'b1;
    @(negedge clk);
    reset_checks("R1");

    // R3: plain back-to-back stream, no flags
    for (int i = 0; i < 10; i++) send(6'(i % 8), 3'(i), 3'(i + 1));
    idle(8);

    // R5: integer producer followed by an address consumer on the same register
    send(6'b010001, 3'd3, 3'd0);
    send(6'b100010, 3'd5, 3'd3);
    send(6'b000011, 3'd1, 3'd1);
    idle(8);
    // R5: two hazards in a row
    send(6'b010100, 3'd2, 3'd0);
    send(6'b110101, 3'd4, 3'd2);
    send(6'b100110, 3'd0, 3'd4);
    idle(8);

    // R6: register mismatch
    send(6'b010001, 3'd3, 3'd0); send(6'b100010, 3'd5, 3'd4); idle(7);
    // R6: producer without integer write
    send(6'b000001, 3'd3, 3'd0); send(6'b100010, 3'd5, 3'd3); idle(7);
    // R6: consumer without address use
    send(6'b010001, 3'd3, 3'd0); send(6'b000010, 3'd5, 3'd3); idle(7);
    // R6: distance two
    send(6'b010001, 3'd3, 3'd0); send(6'b000111, 3'd6, 3'd6);
    send(6'b100010, 3'd5, 3'd3); idle(8);

    // R7: multi-cycle ops of every length, back to back with followers
    send(6'b001000, 3'd1, 3'd0);
    send(6'b001001, 3'd1, 3'd0);
    send(6'b001010, 3'd1, 3'd0);
    send(6'b001011, 3'd1, 3'd0);
    send(6'b000100, 3'd1, 3'd0);
    idle(14);
    // R8: hazard pair sitting behind a hold
    send(6'b001011, 3'd7, 3'd7);
    send(6'b010000, 3'd2, 3'd1);
    send(6'b100000, 3'd3, 3'd2);
    idle(14);

    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [OPC_W-1:0] o;
      o = OPC_W'($urandom);
      if (($urandom % 4) != 0) o[3] = 1'b0;
      if (($urandom % 5) == 0) idle(1);
      send(o, REG_W'($urandom), REG_W'($urandom));
    end
    idle(12);

    // R10: reset in the middle of traffic
    send(6'b011010, 3'd1, 3'd0);
    send(6'b001011, 3'd2, 3'd0);
    send(6'b000101, 3'd3, 3'd0);
    send(6'b000110, 3'd4, 3'd0);
    @(negedge clk);
    rst_n = 1'b0; in_valid_i = 1'b0;
    #1;
    reset_checks("R10");
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) send(6'(i + 16), 3'(i), 3'(i));
    idle(10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule